// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block lets an external bus master read and write a bank of 8-bit configuration registers inside a programmable clock generator. It listens on the open-drain clock and data lines of a standard I2C bus. For each line it receives the sampled level, and it returns one enable that pulls the data line low. The registers leave the block as one flat vector, so the rest of the chip always sees their current values. Writes take effect while the chip is running.

A frame opens with START and the 7-bit device address plus a direction bit. In a write frame, the first byte after the address sets the register pointer and every byte after it is stored. In a read frame, the block sends bytes starting at the pointer. The pointer moves on by one after every data byte and wraps at the top of the bank. It keeps its value through STOP. A bare read frame therefore continues just after the last register touched. To read from any other register, the master first sends a write frame that carries only the pointer. It can follow that with a repeated START and go straight into the read.

Top module: `i2cCfgSlave`

## Requirements
- R1: When the 7-bit address equals `DEV_ADDR`, the block pulls SDA low for the ninth clock pulse of the address byte. On any other address it leaves SDA released for the rest of the frame and changes no register and not the pointer.
- R2: In a write frame, the byte after the address loads the pointer. Each following byte is written to the register at the pointer and is acknowledged, and the pointer then advances by one.
- R3: The pointer wraps from register `NUM_REGS-1` to register 0. A pointer byte is taken modulo `NUM_REGS`, which must be a power of two.
- R4: In a read frame, the block sends the register at the pointer MSB first and advances the pointer by one. It sends the next register each time the master acknowledges (SDA low on the ninth pulse). After a NACK it leaves SDA released until the next START or STOP.
- R5: The pointer survives STOP. A read frame with no pointer byte starts at the register after the one last written or read.
- R6: A write frame that carries only a pointer byte, followed by a repeated START and a read address, returns data starting at that pointer.
- R7: A START or STOP before the eighth bit of a byte is complete discards the partial byte. No register changes and the pointer does not move.
- R8: After reset every register is 0, the pointer is 0 and SDA is released.
- R9: The SDA pull enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sdaPullLow | output | 1 | When high, the pad pulls SDA low |
| cfgRegs | output | NUM_REGS*8 | Register bank, register i in bits [8i+7:8i] |

## Verification
The assertions assume that the bus obeys I2C ordering. Data changes only while SCL is low, apart from START and STOP. SCL stays in each phase for several system clocks, so the two-flop synchronizer never merges an SCL edge with an SDA edge. The bench master holds every SCL phase for twenty system clocks. It waits five clocks after each falling SCL edge before it moves SDA, and it never drives START or STOP while the slave holds the line low. Under these conditions an SDA edge while SCL is high can only be a START or a STOP, never data.

// File: rtl/i2cCfgPkg.sv
package i2cCfgPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/i2cCfgSync.sv
module i2cCfgSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '1;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/i2cCfgCtrl.sv
module i2cCfgCtrl
  import i2cCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaPullLow
);

  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] BYTE_END = 4'd9;

  busState_t state;
  logic [3:0] bitCnt;
  logic sclD, sdaD;
  logic ackDrive, txActive, masterAck;
  logic startSeen, stopSeen, sclRise, sclFall, active, addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign active    = (state != ST_IDLE) && (state != ST_SKIP) && !startSeen && !stopSeen;
  assign addrHit   = (rxByte[7:1] == DEV_ADDR);

  always_comb begin
    strobe = '0;
    if (active) begin
      if (sclRise && bitCnt < ACK_SLOT) strobe.shiftIn = 1'b1;
      if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          case (state)
            ST_PTR:   strobe.loadPtr = 1'b1;
            ST_WDATA: begin strobe.writeReg = 1'b1; strobe.incPtr = 1'b1; end
            ST_RDATA: strobe.incPtr = 1'b1;
            default:  ;
          endcase
        end else if (bitCnt == BYTE_END) begin
          if (state == ST_ADDR && rxByte[0]) strobe.loadTx = 1'b1;
          if (state == ST_RDATA && masterAck) strobe.loadTx = 1'b1;
        end else if (bitCnt != 4'd0 && state == ST_RDATA && txActive) begin
          strobe.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startSeen) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (active) begin
      if (sclRise) begin
        if (bitCnt < BYTE_END) bitCnt <= bitCnt + 4'd1;
        if (bitCnt == ACK_SLOT && state == ST_RDATA) masterAck <= ~sdaS;
      end
      if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          case (state)
            ST_ADDR: begin
              if (addrHit) ackDrive <= 1'b1;
              else         state    <= ST_SKIP;
            end
            ST_PTR, ST_WDATA: ackDrive <= 1'b1;
            ST_RDATA:         txActive <= 1'b0;
            default: ;
          endcase
        end else if (bitCnt == BYTE_END) begin
          bitCnt   <= '0;
          ackDrive <= 1'b0;
          case (state)
            ST_ADDR: begin
              if (rxByte[0]) begin
                state    <= ST_RDATA;
                txActive <= 1'b1;
              end else begin
                state <= ST_PTR;
              end
            end
            ST_PTR: state <= ST_WDATA;
            ST_RDATA: begin
              if (masterAck) txActive <= 1'b1;
              else           state    <= ST_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sdaPullLow = ackDrive | (txActive & ~txBit);

  // R1: a frame for another device leaves the line released
  a_r1_skip_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && $past(state) == ST_SKIP && !$past(masterAck)) |-> !ackDrive && !txActive);

  // R8: no pull with the bus idle
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow);

  // R9: the pull never moves while the synchronized clock stays high
  a_r9_sda_steady: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD) |=> (!sclS || $stable(sdaPullLow)));

  // R4: data bits are only driven inside a read frame
  a_r4_tx_in_read: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> state == ST_RDATA);

endmodule

// File: rtl/i2cCfgData.sv
module i2cCfgData
  import i2cCfgPkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  sdaS,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] cfgRegs
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [7:0]       regFile [NUM_REGS];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       shiftReg, txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txReg    <= '0;
      ptr      <= '0;
    end else begin
      if (strobe.shiftIn) shiftReg <= {shiftReg[6:0], sdaS};
      if (strobe.loadPtr) ptr <= shiftReg[PTR_W-1:0];
      else if (strobe.incPtr) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      if (strobe.loadTx) txReg <= regFile[ptr];
      else if (strobe.shiftTx) txReg <= {txReg[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strobe.writeReg) begin
      regFile[ptr] <= shiftReg;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfgRegs[g*8 +: 8] = regFile[g];
  end

  assign rxByte = shiftReg;
  assign txBit  = txReg[7];

  // R3: the pointer wraps to zero past the top register
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incPtr && !strobe.loadPtr && ptr == LAST) |=> ptr == '0);

  // R2: the pointer steps by one below the top
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incPtr && !strobe.loadPtr && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

  // R7: the bank changes only on a committed byte
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeReg |=> $stable(cfgRegs));

endmodule

// File: rtl/i2cCfgSlave.sv
module i2cCfgSlave
  import i2cCfgPkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] cfgRegs
);

  logic [1:0] busS;
  logic [7:0] rxByte;
  logic       txBit;
  dpStrobe_t  strobe;

  i2cCfgSync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({sclIn, sdaIn}),
    .syncOut (busS)
  );

  i2cCfgCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclS       (busS[1]),
    .sdaS       (busS[0]),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .strobe     (strobe),
    .sdaPullLow (sdaPullLow)
  );

  i2cCfgData #(.NUM_REGS(NUM_REGS)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sdaS    (busS[0]),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .cfgRegs (cfgRegs)
  );

endmodule

// File: tb/i2cCfgSlave_bench.sv
module i2cCfgSlave_bench;

  localparam int NREG = 16;
  localparam int H = 20;
  localparam int Q = 5;
  localparam logic [7:0] WADDR = 8'hB4;
  localparam logic [7:0] RADDR = 8'hB5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic [NREG*8-1:0] cfgRegs;
  logic sdaLine;

  int tests = 0;
  int fails = 0;
  int r9Bad = 0;
  logic [7:0] mReg [NREG];
  int mPtr = 0;

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  i2cCfgSlave u_i2cCfgSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .cfgRegs(cfgRegs)
  );

  logic prevScl = 1'b1;
  logic prevPull = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaPullLow !== prevPull)) r9Bad++;
    prevScl  <= sclM;
    prevPull <= sdaPullLow;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkBank(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, cfgRegs[i*8 +: 8], mReg[i]);
  endtask

  task automatic busStart;
    sdaM = 1'b1; sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busRepStart;
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitClk(H);
      sclM = 1'b1; waitClk(H);
      sclM = 1'b0; waitClk(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H/2);
    acked = ~sdaLine; waitClk(H/2);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(H);
      sclM = 1'b1; waitClk(H/2);
      b[i] = sdaLine; waitClk(H/2);
      sclM = 1'b0; waitClk(Q);
    end
    sdaM = ~ackIt; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(Q);
    sdaM = 1'b1;
  endtask

  task automatic modelWrite(input logic [7:0] b);
    mReg[mPtr] = b;
    mPtr = (mPtr + 1) % NREG;
  endtask

  task automatic readExpect(input string tag, input logic ackIt);
    logic [7:0] got;
    recvByte(ackIt, got);
    check(tag, got, mReg[mPtr]);
    mPtr = (mPtr + 1) % NREG;
  endtask

  task automatic writeFrame(input string tag, input int p, input logic [7:0] d [], input logic ackNeeded);
    logic a;
    busStart();
    sendByte(WADDR, a); check({tag, " R1 addr ack"}, a, 1'b1);
    sendByte(8'(p), a); check({tag, " R2 ptr ack"}, a, 1'b1);
    mPtr = p % NREG;
    foreach (d[i]) begin
      sendByte(d[i], a); check({tag, " R2 data ack"}, a, 1'b1);
      modelWrite(d[i]);
    end
    if (ackNeeded) busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] got;
    for (int i = 0; i < NREG; i++) mReg[i] = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R8: reset state
    check("R8 sda released", sdaPullLow, 1'b0);
    checkBank("R8 bank zero");

    // R2: write three bytes from register 3
    writeFrame("t1", 3, '{8'h11, 8'h22, 8'h33}, 1'b1);
    checkBank("R2 bank after write");

    // R1: another device address is ignored
    busStart();
    sendByte(8'h60, a); check("R1 no ack on mismatch", a, 1'b0);
    sendByte(8'h05, a); check("R1 no ack after mismatch", a, 1'b0);
    sendByte(8'hEE, a); check("R1 no ack data", a, 1'b0);
    busStop();
    checkBank("R1 bank untouched");

    // fill registers 0..7
    writeFrame("t2", 0, '{8'h10, 8'h12, 8'h14, 8'h16, 8'h18, 8'h1A, 8'h1C, 8'h1E}, 1'b1);
    // R3: write across the top of the bank
    writeFrame("t3", 14, '{8'hE1, 8'hE2, 8'hE3}, 1'b1);
    checkBank("R3 wrap write");

    // R5: bare read continues after last register written (register 1)
    busStart();
    sendByte(RADDR, a); check("R5 read addr ack", a, 1'b1);
    readExpect("R5 bare read b0", 1'b1);
    readExpect("R4 read b1", 1'b1);
    readExpect("R4 read b2 nack", 1'b0);
    waitClk(H);
    check("R4 released after nack", sdaPullLow, 1'b0);
    busStop();

    // R6: pointer-only write, repeated start, read across the wrap
    writeFrame("t4", 14, '{}, 1'b0);
    busRepStart();
    sendByte(RADDR, a); check("R6 read addr ack", a, 1'b1);
    readExpect("R6 read at 14", 1'b1);
    readExpect("R3 read at 15", 1'b1);
    readExpect("R3 read wraps to 0", 1'b0);
    busStop();

    // R7: STOP inside a data byte
    writeFrame("t5", 5, '{}, 1'b0);
    sendBits(8'hFF, 4);
    busStop();
    checkBank("R7 stop abort bank");
    busStart();
    sendByte(RADDR, a); check("R7 read addr ack", a, 1'b1);
    readExpect("R7 pointer unmoved after stop abort", 1'b0);
    busStop();

    // R7: repeated START inside a data byte
    writeFrame("t6", 9, '{}, 1'b0);
    sendBits(8'h00, 3);
    busRepStart();
    sendByte(RADDR, a); check("R7 sr read addr ack", a, 1'b1);
    readExpect("R7 pointer unmoved after start abort", 1'b0);
    busStop();
    checkBank("R7 start abort bank");

    // R5: bare read after a read continues (pointer now 10)
    busStart();
    sendByte(RADDR, a); check("R5 second bare read ack", a, 1'b1);
    readExpect("R5 read continues at 10", 1'b0);
    busStop();

    // R9: pull enable steady while SCL high
    check("R9 sda steady during scl high", r9Bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule